// File: doc/BRIEF.md
# Fully Associative Translation Cache with Refill

This block translates virtual page numbers into physical frame numbers through a small, fully associative cache of recent translations. Each lookup compares the incoming page number against every stored entry in the same cycle. On a match the frame number is returned on the next clock, and the page table is not touched. When no entry matches, the block reads the page table through a read port and then completes the request. If the page is present, the fetched entry replaces a victim entry. If the page is absent, the block reports a fault and installs nothing.

Each entry holds a valid flag, the page number, the frame number, a modified flag and a writable flag. The victim is the lowest-numbered empty entry if one exists. Otherwise a round-robin pointer picks it. When a live entry is displaced, its page number and modified flag leave through a write-back port so that the page table's copy stays current. A write that hits a writable entry marks it modified. A write to a non-writable page is refused with a fault. A flush input empties the cache in one cycle.

Requests are taken one at a time. Hits can be issued back to back. A miss holds the request port off until the page-table read completes.

Top module: `tlb_xlate`

## Requirements
- R1: A request whose page number equals that of a valid entry is a hit. On the clock after acceptance, `rsp_valid`=1, `rsp_hit`=1 and `rsp_pfn` is the stored frame, and `pt_rd_en` is not raised for that request.
- R2: A request that matches no valid entry raises `pt_rd_en` with `pt_rd_vpn` equal to the request page. `pt_rd_en` stays high until `pt_rd_valid`. The response comes on the clock after `pt_rd_valid`, with `rsp_hit`=0 and `rsp_pfn` equal to the fetched frame. `req_ready` is 0 while the read is outstanding.
- R3: A refill loads every field from the page-table read port: the frame, the writable flag, and a modified flag equal to the fetched modified flag OR'ed with (the request is a write to a writable page).
- R4: The victim is the lowest-indexed invalid entry. When all entries are valid, a round-robin pointer picks the victim. The pointer starts at 0 after reset, advances by one (wrapping) on each such eviction, and a flush does not change it.
- R5: Displacing a valid entry produces a one-cycle `pt_wb_en` pulse in the same cycle as the refill response. The pulse carries the evicted page number on `pt_wb_vpn` and its modified flag on `pt_wb_dirty`. Filling an invalid entry produces no pulse.
- R6: A write hit on a writable entry sets that entry's modified flag. The flag is observed later through `pt_wb_dirty` when the entry is evicted.
- R7: A write to a page whose writable flag is 0 responds with `rsp_fault`=1 and `rsp_pfn`=0, and leaves the modified flag unchanged. On a miss the entry is still installed.
- R8: If the fetched entry has `pt_rd_present`=0, the response has `rsp_fault`=1, `rsp_hit`=0 and `rsp_pfn`=0, no entry is installed, and no write-back occurs. A repeat request walks again.
- R9: `flush` clears every valid flag at the next clock without any write-back. `req_ready` is 0 in a cycle with `flush` high, and a flush takes precedence over a refill completing in the same cycle.
- R10: After reset, no entry is valid and `rsp_valid`, `pt_rd_en` and `pt_wb_en` are 0. `req_ready` becomes 1 once the synchronised reset has been released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Invalidate all entries |
| req_valid | input | 1 | Translation request present |
| req_vpn | input | VPN_W | Virtual page number of request |
| req_write | input | 1 | Request is a write |
| req_ready | output | 1 | Request is accepted this cycle if valid |
| rsp_valid | output | 1 | Response pulse |
| rsp_hit | output | 1 | Response came from the cache |
| rsp_fault | output | 1 | Page absent or write refused |
| rsp_pfn | output | PFN_W | Translated frame number (0 on fault) |
| pt_rd_en | output | 1 | Page-table read request |
| pt_rd_vpn | output | VPN_W | Page number to read |
| pt_rd_valid | input | 1 | Page-table read data valid |
| pt_rd_present | input | 1 | Fetched page is present |
| pt_rd_pfn | input | PFN_W | Fetched frame number |
| pt_rd_dirty | input | 1 | Fetched modified flag |
| pt_rd_writable | input | 1 | Fetched writable flag |
| pt_wb_en | output | 1 | Write-back pulse for an evicted entry |
| pt_wb_vpn | output | VPN_W | Page number of the evicted entry |
| pt_wb_dirty | output | 1 | Modified flag of the evicted entry |

## Verification
The bench builds the block with ENTRIES=4, VPN_W=6 and PFN_W=5. With four entries the cache fills after a handful of misses, so the round-robin pointer wraps several times within a short run. The narrow page number lets a small computed page table in the bench cover present and absent pages, writable and read-only pages, and pages that start out modified. The bench also varies the page-table read latency, so both single-cycle and multi-cycle walks occur.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_WALK = 1'b1
  } tlb_state_e;

endpackage

// File: rtl/tlb_match.sv
module tlb_match #(
  parameter int N     = 8,
  parameter int VPN_W = 8,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]            valid,
  input  logic [N-1:0][VPN_W-1:0] tags,
  input  logic [VPN_W-1:0]        key,
  output logic                    hit,
  output logic [N-1:0]            hit_vec,
  output logic [IDX_W-1:0]        hit_idx
);

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign hit_vec[g] = valid[g] && (tags[g] == key);
  end

  assign hit = |hit_vec;

  // At most one line matches, so OR the indices of the matching lines.
  always_comb begin
    hit_idx = '0;
    for (int i = 0; i < N; i++) begin
      if (hit_vec[i]) hit_idx = hit_idx | IDX_W'(i);
    end
  end

endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
  parameter int N = 8,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     valid,
  input  logic             take,
  output logic [IDX_W-1:0] vic_idx,
  output logic             vic_live
);

  logic [IDX_W-1:0] rr_q, rr_d;
  logic [IDX_W-1:0] free_idx;
  logic             all_live;

  assign all_live = &valid;

  always_comb begin
    free_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!valid[i]) free_idx = IDX_W'(i);
    end
  end

  assign vic_idx  = all_live ? rr_q : free_idx;
  assign vic_live = all_live;

  always_comb begin
    rr_d = rr_q;
    if (take && all_live) begin
      rr_d = (rr_q == IDX_W'(N - 1)) ? '0 : rr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rr_q <= '0;
    else        rr_q <= rr_d;
  end

  // R4: the round-robin pointer moves only when a live line is displaced
  a_r4_rr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(take && all_live) |=> (rr_q == $past(rr_q)));

endmodule

// File: rtl/tlb_store.sv
module tlb_store #(
  parameter int N     = 8,
  parameter int VPN_W = 8,
  parameter int PFN_W = 6,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    flush,
  input  logic                    ins_en,
  input  logic [IDX_W-1:0]        ins_idx,
  input  logic [VPN_W-1:0]        ins_vpn,
  input  logic [PFN_W-1:0]        ins_pfn,
  input  logic                    ins_dirty,
  input  logic                    ins_wr,
  input  logic                    mark_en,
  input  logic [IDX_W-1:0]        mark_idx,
  output logic [N-1:0]            valid,
  output logic [N-1:0][VPN_W-1:0] vpn,
  output logic [N-1:0][PFN_W-1:0] pfn,
  output logic [N-1:0]            dirty,
  output logic [N-1:0]            wr_ok
);

  for (genvar g = 0; g < N; g++) begin : g_line
    logic             v_d, d_d, w_d;
    logic [VPN_W-1:0] t_d;
    logic [PFN_W-1:0] f_d;
    logic             load, mark;

    assign load = ins_en && (ins_idx == IDX_W'(g));
    assign mark = mark_en && (mark_idx == IDX_W'(g));

    always_comb begin
      v_d = valid[g];
      d_d = dirty[g];
      w_d = wr_ok[g];
      t_d = vpn[g];
      f_d = pfn[g];
      if (load) begin
        v_d = 1'b1;
        d_d = ins_dirty;
        w_d = ins_wr;
        t_d = ins_vpn;
        f_d = ins_pfn;
      end else if (mark) begin
        d_d = 1'b1;
      end
      if (flush) v_d = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        valid[g] <= 1'b0;
        dirty[g] <= 1'b0;
        wr_ok[g] <= 1'b0;
        vpn[g]   <= '0;
        pfn[g]   <= '0;
      end else begin
        valid[g] <= v_d;
        dirty[g] <= d_d;
        wr_ok[g] <= w_d;
        vpn[g]   <= t_d;
        pfn[g]   <= f_d;
      end
    end
  end

  // R9: a flush empties the cache at the next edge, refill or not
  a_r9_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (valid == '0));

endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate #(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 8,
  parameter int PFN_W   = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             req_valid,
  input  logic [VPN_W-1:0] req_vpn,
  input  logic             req_write,
  output logic             req_ready,
  output logic             rsp_valid,
  output logic             rsp_hit,
  output logic             rsp_fault,
  output logic [PFN_W-1:0] rsp_pfn,
  output logic             pt_rd_en,
  output logic [VPN_W-1:0] pt_rd_vpn,
  input  logic             pt_rd_valid,
  input  logic             pt_rd_present,
  input  logic [PFN_W-1:0] pt_rd_pfn,
  input  logic             pt_rd_dirty,
  input  logic             pt_rd_writable,
  output logic             pt_wb_en,
  output logic [VPN_W-1:0] pt_wb_vpn,
  output logic             pt_wb_dirty
);
  import tlb_pkg::*;

  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  // reset: asynchronous assertion, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ok = rst_sync_q[1];

  // state
  tlb_state_e       state_q, state_d;
  logic [VPN_W-1:0] vpn_q, vpn_d;
  logic             wr_q, wr_d;
  logic             rsp_valid_d, rsp_hit_d, rsp_fault_d;
  logic [PFN_W-1:0] rsp_pfn_d;
  logic             wb_en_d, wb_dirty_d;
  logic [VPN_W-1:0] wb_vpn_d;

  // storage and helpers
  logic [ENTRIES-1:0]            ln_valid, ln_dirty, ln_wr;
  logic [ENTRIES-1:0][VPN_W-1:0] ln_vpn;
  logic [ENTRIES-1:0][PFN_W-1:0] ln_pfn;
  logic                          lk_hit;
  logic [ENTRIES-1:0]            lk_vec;
  logic [IDX_W-1:0]              lk_idx;
  logic [IDX_W-1:0]              vic_idx;
  logic                          vic_live;
  logic                          ins_en, ins_dirty, mark_en, accept, refused;

  tlb_match #(.N(ENTRIES), .VPN_W(VPN_W)) u_match (
    .valid   (ln_valid),
    .tags    (ln_vpn),
    .key     (req_vpn),
    .hit     (lk_hit),
    .hit_vec (lk_vec),
    .hit_idx (lk_idx)
  );

  tlb_victim #(.N(ENTRIES)) u_victim (
    .clk      (clk),
    .rst_n    (rst_ok),
    .valid    (ln_valid),
    .take     (ins_en),
    .vic_idx  (vic_idx),
    .vic_live (vic_live)
  );

  tlb_store #(.N(ENTRIES), .VPN_W(VPN_W), .PFN_W(PFN_W)) u_store (
    .clk       (clk),
    .rst_n     (rst_ok),
    .flush     (flush),
    .ins_en    (ins_en),
    .ins_idx   (vic_idx),
    .ins_vpn   (vpn_q),
    .ins_pfn   (pt_rd_pfn),
    .ins_dirty (ins_dirty),
    .ins_wr    (pt_rd_writable),
    .mark_en   (mark_en),
    .mark_idx  (lk_idx),
    .valid     (ln_valid),
    .vpn       (ln_vpn),
    .pfn       (ln_pfn),
    .dirty     (ln_dirty),
    .wr_ok     (ln_wr)
  );

  assign req_ready = rst_ok && (state_q == ST_IDLE) && !flush;
  assign accept    = req_valid && req_ready;
  assign pt_rd_en  = (state_q == ST_WALK);
  assign pt_rd_vpn = vpn_q;
  assign ins_dirty = pt_rd_dirty || (wr_q && pt_rd_writable);

  // next state
  always_comb begin
    state_d     = state_q;
    vpn_d       = vpn_q;
    wr_d        = wr_q;
    rsp_valid_d = 1'b0;
    rsp_hit_d   = 1'b0;
    rsp_fault_d = 1'b0;
    rsp_pfn_d   = '0;
    wb_en_d     = 1'b0;
    wb_vpn_d    = pt_wb_vpn;
    wb_dirty_d  = pt_wb_dirty;
    ins_en      = 1'b0;
    mark_en     = 1'b0;
    refused     = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (accept) begin
          if (lk_hit) begin
            refused     = req_write && !ln_wr[lk_idx];
            rsp_valid_d = 1'b1;
            rsp_hit_d   = 1'b1;
            rsp_fault_d = refused;
            rsp_pfn_d   = refused ? '0 : ln_pfn[lk_idx];
            mark_en     = req_write && ln_wr[lk_idx];
          end else begin
            state_d = ST_WALK;
            vpn_d   = req_vpn;
            wr_d    = req_write;
          end
        end
      end
      ST_WALK: begin
        if (pt_rd_valid) begin
          state_d     = ST_IDLE;
          rsp_valid_d = 1'b1;
          if (!pt_rd_present) begin
            rsp_fault_d = 1'b1;
          end else begin
            refused     = wr_q && !pt_rd_writable;
            ins_en      = 1'b1;
            rsp_fault_d = refused;
            rsp_pfn_d   = refused ? '0 : pt_rd_pfn;
            wb_en_d     = vic_live;
            wb_vpn_d    = ln_vpn[vic_idx];
            wb_dirty_d  = ln_dirty[vic_idx];
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) begin
      state_q     <= ST_IDLE;
      vpn_q       <= '0;
      wr_q        <= 1'b0;
      rsp_valid   <= 1'b0;
      rsp_hit     <= 1'b0;
      rsp_fault   <= 1'b0;
      rsp_pfn     <= '0;
      pt_wb_en    <= 1'b0;
      pt_wb_vpn   <= '0;
      pt_wb_dirty <= 1'b0;
    end else begin
      state_q     <= state_d;
      vpn_q       <= vpn_d;
      wr_q        <= wr_d;
      rsp_valid   <= rsp_valid_d;
      rsp_hit     <= rsp_hit_d;
      rsp_fault   <= rsp_fault_d;
      rsp_pfn     <= rsp_pfn_d;
      pt_wb_en    <= wb_en_d;
      pt_wb_vpn   <= wb_vpn_d;
      pt_wb_dirty <= wb_dirty_d;
    end
  end

  // R1: a hit answers on the next edge from the cache
  a_r1_hit_next: assert property (@(posedge clk) disable iff (!rst_ok)
    (accept && lk_hit) |=> (rsp_valid && rsp_hit));

  // R1: no two lines ever hold the same page
  a_r1_unique: assert property (@(posedge clk) disable iff (!rst_ok)
    $onehot0(lk_vec));

  // R2: the table is read only while requests are held off
  a_r2_walk_blocks: assert property (@(posedge clk) disable iff (!rst_ok)
    pt_rd_en |-> !req_ready);

  // R2: a walk keeps asking until data arrives
  a_r2_walk_holds: assert property (@(posedge clk) disable iff (!rst_ok)
    (pt_rd_en && !pt_rd_valid) |=> (pt_rd_en && $stable(pt_rd_vpn)));

  // R5: write-back travels with a refill response
  a_r5_wb_with_refill: assert property (@(posedge clk) disable iff (!rst_ok)
    pt_wb_en |-> (rsp_valid && !rsp_hit));

  // R8: an absent page leaves the cache untouched
  a_r8_absent_no_install: assert property (@(posedge clk) disable iff (!rst_ok)
    (pt_rd_en && pt_rd_valid && !pt_rd_present && !flush)
      |=> (ln_valid == $past(ln_valid) && !pt_wb_en));

  // R7: a refused write never reports a frame
  a_r7_fault_zero: assert property (@(posedge clk) disable iff (!rst_ok)
    (rsp_valid && rsp_fault) |-> (rsp_pfn == '0));

endmodule

// File: tb/tlb_xlate_test.sv
`timescale 1ns/1ps
module tlb_xlate_test;
  localparam int N     = 4;
  localparam int VPN_W = 6;
  localparam int PFN_W = 5;
  localparam int PAGES = 1 << VPN_W;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             flush;
  logic             req_valid;
  logic [VPN_W-1:0] req_vpn;
  logic             req_write;
  logic             req_ready;
  logic             rsp_valid, rsp_hit, rsp_fault;
  logic [PFN_W-1:0] rsp_pfn;
  logic             pt_rd_en;
  logic [VPN_W-1:0] pt_rd_vpn;
  logic             pt_rd_valid, pt_rd_present, pt_rd_dirty, pt_rd_writable;
  logic [PFN_W-1:0] pt_rd_pfn;
  logic             pt_wb_en, pt_wb_dirty;
  logic [VPN_W-1:0] pt_wb_vpn;

  always #2.5 clk = ~clk;

  tlb_xlate #(.ENTRIES(N), .VPN_W(VPN_W), .PFN_W(PFN_W)) uut (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .req_valid(req_valid), .req_vpn(req_vpn), .req_write(req_write),
    .req_ready(req_ready),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_fault(rsp_fault),
    .rsp_pfn(rsp_pfn),
    .pt_rd_en(pt_rd_en), .pt_rd_vpn(pt_rd_vpn), .pt_rd_valid(pt_rd_valid),
    .pt_rd_present(pt_rd_present), .pt_rd_pfn(pt_rd_pfn),
    .pt_rd_dirty(pt_rd_dirty), .pt_rd_writable(pt_rd_writable),
    .pt_wb_en(pt_wb_en), .pt_wb_vpn(pt_wb_vpn), .pt_wb_dirty(pt_wb_dirty)
  );

  // computed page table
  logic             tbl_present [PAGES];
  logic [PFN_W-1:0] tbl_pfn     [PAGES];
  logic             tbl_dirty   [PAGES];
  logic             tbl_wr      [PAGES];
  int               pt_lat;
  int               lat_cnt;
  int               walks_seen;

  assign pt_rd_valid    = pt_rd_en && (lat_cnt >= pt_lat);
  assign pt_rd_present  = tbl_present[pt_rd_vpn];
  assign pt_rd_pfn      = tbl_pfn[pt_rd_vpn];
  assign pt_rd_dirty    = tbl_dirty[pt_rd_vpn];
  assign pt_rd_writable = tbl_wr[pt_rd_vpn];

  always @(posedge clk) begin
    if (pt_rd_en && !pt_rd_valid) lat_cnt <= lat_cnt + 1;
    else                          lat_cnt <= 0;
    if (pt_rd_en && pt_rd_valid)  walks_seen <= walks_seen + 1;
  end

  // scoreboard
  typedef struct {
    logic             hit;
    logic             fault;
    logic [PFN_W-1:0] pfn;
    int               walks;
    string            tag;
  } rsp_item_t;
  typedef struct {
    logic [VPN_W-1:0] vpn;
    logic             dirty;
  } wb_item_t;

  rsp_item_t rsp_q[$];
  wb_item_t  wb_q[$];
  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  // bench model of the cache
  logic             m_v   [N];
  logic [VPN_W-1:0] m_vpn [N];
  logic [PFN_W-1:0] m_pfn [N];
  logic             m_d   [N];
  logic             m_w   [N];
  int               m_rr;
  int               m_walks;

  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      tests++;
      if (rsp_q.size() == 0) begin
        fails++;
        $display("FAIL R1 unexpected response hit=%0b fault=%0b pfn=%0d expected none",
                 rsp_hit, rsp_fault, rsp_pfn);
      end else begin
        rsp_item_t e;
        e = rsp_q.pop_front();
        if (rsp_hit !== e.hit || rsp_fault !== e.fault || rsp_pfn !== e.pfn ||
            walks_seen != e.walks) begin
          fails++;
          $display("FAIL %s hit=%0b fault=%0b pfn=%0d walks=%0d expected hit=%0b fault=%0b pfn=%0d walks=%0d",
                   e.tag, rsp_hit, rsp_fault, rsp_pfn, walks_seen,
                   e.hit, e.fault, e.pfn, e.walks);
        end
      end
    end
    if (rst_n && pt_wb_en) begin
      tests++;
      if (wb_q.size() == 0) begin
        fails++;
        $display("FAIL R5 unexpected write-back vpn=%0d dirty=%0b expected none",
                 pt_wb_vpn, pt_wb_dirty);
      end else begin
        wb_item_t w;
        w = wb_q.pop_front();
        if (pt_wb_vpn !== w.vpn || pt_wb_dirty !== w.dirty) begin
          fails++;
          $display("FAIL R5/R6 write-back vpn=%0d dirty=%0b expected vpn=%0d dirty=%0b",
                   pt_wb_vpn, pt_wb_dirty, w.vpn, w.dirty);
        end
      end
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // driver: predict the answer, push it, present the request
  task automatic do_req(input logic [VPN_W-1:0] vpn, input logic wr);
    rsp_item_t e;
    int hi;
    int vic;
    hi = -1;
    while (!req_ready) @(negedge clk);
    for (int i = 0; i < N; i++) if (m_v[i] && m_vpn[i] == vpn) hi = i;
    if (hi >= 0) begin
      e.hit   = 1'b1;
      e.fault = wr && !m_w[hi];
      e.pfn   = e.fault ? '0 : m_pfn[hi];
      e.tag   = e.fault ? "R7 write refused on hit" : (wr ? "R6 write hit" : "R1 hit");
      if (wr && m_w[hi]) m_d[hi] = 1'b1;
    end else begin
      m_walks++;
      e.hit = 1'b0;
      if (!tbl_present[vpn]) begin
        e.fault = 1'b1;
        e.pfn   = '0;
        e.tag   = "R8 absent page";
      end else begin
        wb_item_t w;
        vic = -1;
        for (int i = N - 1; i >= 0; i--) if (!m_v[i]) vic = i;
        if (vic < 0) begin
          vic     = m_rr;
          w.vpn   = m_vpn[vic];
          w.dirty = m_d[vic];
          wb_q.push_back(w);
          tbl_dirty[m_vpn[vic]] = m_d[vic];
          m_rr = (m_rr + 1) % N;
        end
        m_v[vic]   = 1'b1;
        m_vpn[vic] = vpn;
        m_pfn[vic] = tbl_pfn[vpn];
        m_w[vic]   = tbl_wr[vpn];
        m_d[vic]   = tbl_dirty[vpn] || (wr && tbl_wr[vpn]);
        e.fault    = wr && !tbl_wr[vpn];
        e.pfn      = e.fault ? '0 : tbl_pfn[vpn];
        e.tag      = e.fault ? "R7 write refused on refill" : "R2/R3/R4 refill";
      end
    end
    e.walks = m_walks;
    rsp_q.push_back(e);
    req_valid = 1'b1;
    req_vpn   = vpn;
    req_write = wr;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic do_flush();
    while (!req_ready) @(negedge clk);
    flush = 1'b1;
    #0.1;
    check("R9 req_ready low during flush", {31'd0, req_ready}, 32'd0);
    @(negedge clk);
    flush = 1'b0;
    for (int i = 0; i < N; i++) m_v[i] = 1'b0;
  endtask

  task automatic drain();
    int k;
    k = 0;
    while ((rsp_q.size() != 0 || wb_q.size() != 0) && k < 50) begin
      @(negedge clk);
      k++;
    end
  endtask

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests + 1, fails);
      $finish;
    end
  end

  initial begin
    for (int v = 0; v < PAGES; v++) begin
      tbl_present[v] = (v % 7) != 3;
      tbl_pfn[v]     = PFN_W'((v * 5 + 3) % (1 << PFN_W));
      tbl_dirty[v]   = (v % 5) == 0;
      tbl_wr[v]      = (v % 2) == 0;
    end
    for (int i = 0; i < N; i++) begin
      m_v[i] = 1'b0; m_vpn[i] = '0; m_pfn[i] = '0; m_d[i] = 1'b0; m_w[i] = 1'b0;
    end
    m_rr = 0; m_walks = 0; pt_lat = 0; lat_cnt = 0; walks_seen = 0;
    flush = 1'b0; req_valid = 1'b0; req_vpn = '0; req_write = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R10 reset state
    check("R10 req_ready after reset", {31'd0, req_ready}, 32'd1);
    check("R10 rsp_valid after reset", {31'd0, rsp_valid}, 32'd0);
    check("R10 pt_rd_en after reset",  {31'd0, pt_rd_en},  32'd0);
    check("R10 pt_wb_en after reset",  {31'd0, pt_wb_en},  32'd0);

    do_req(6'd1, 1'b0);   // R2 miss into line 0
    do_req(6'd1, 1'b0);   // R1 hit
    do_req(6'd2, 1'b1);   // R3 write miss on writable page
    do_req(6'd3, 1'b0);   // R8 absent
    do_req(6'd3, 1'b0);   // R8 walks again
    do_req(6'd5, 1'b0);
    do_req(6'd6, 1'b0);   // cache full
    do_req(6'd1, 1'b1);   // R7 refused write hit
    do_req(6'd6, 1'b1);   // R6 sets modified
    do_req(6'd6, 1'b0);   // back-to-back hit
    do_req(6'd8, 1'b0);   // R4/R5 evict line 0
    do_req(6'd9, 1'b0);
    do_req(6'd11, 1'b1);  // R7 refused write on refill
    do_req(6'd12, 1'b0);
    do_req(6'd13, 1'b0);  // R4 pointer wraps
    pt_lat = 3;
    do_req(6'd2, 1'b0);   // R2 multi-cycle walk
    do_req(6'd2, 1'b1);
    drain();
    do_flush();           // R9
    do_req(6'd2, 1'b0);   // R9 must walk again, R4 lowest free line
    do_req(6'd13, 1'b0);
    pt_lat = 1;
    for (int i = 0; i < 40; i++) begin
      do_req(VPN_W'((i * 7 + 3) % 16), (i % 3) == 0);
      if (i == 20) begin
        drain();
        do_flush();
      end
    end
    pt_lat = 0;
    drain();
    repeat (3) @(negedge clk);
    check("R5 no pending write-back", wb_q.size(), 0);
    check("R1 no pending response", rsp_q.size(), 0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule